// File: doc/BRIEF.md
# Graphics SDRAM Command Decoder with Power-State Tracking

This block watches the command bus of a graphics SDRAM and turns each rising clock edge into a single command code. It reads the clock-enable level from the current edge and from the previous edge. That pair is what separates power-down entry from a plain NOP or deselect. It also separates self-refresh entry from an ordinary auto refresh, and it recognises the wake-up edges. The chip-select, row-strobe, column-strobe, write-enable, bank and address pins are taken from the current edge only.

A three-state tracker (active, power-down, self-refresh) follows the device's power state. After a wake-up edge, a down-counter opens a quiet window. Its length is one parameter for power-down wake-up and another for self-refresh wake-up. Inside that window, only NOP or deselect is accepted. All outputs are registered and appear one clock after the edge they describe. They are the command code, the bank, the row or column address, an auto-precharge flag, the power state, and an illegal flag. A monitor or a protocol checker next to a memory controller would use the block.

Top module: `gsdram_cmd_tracker`

## Requirements
- R1: While `rst` is high, the outputs settle to command 0 (deselect), power state 0 (active), illegal low, bank 0, address 0 and auto-precharge low.
- R2: With clock enable high on both edges and pins {cs_n,ras_n,cas_n,we_n}, the command codes are as follows. 1xxx with any pattern other than 1110 gives 0 (deselect). 1110 gives 2 (termination disable). 0111 gives 1 (NOP). 0001 gives 12 (auto refresh). 0000 gives 3 (mode set) when ba[0]=0 and 4 (extended mode set) when ba[0]=1. None of these is flagged illegal.
- R3: Pins 0011 give code 5 (activate), with bank = ba and addr_o = the full 12-bit address as the row.
- R4: Pins 0101 (read) and 0100 (write) set addr_o[6:0] = {A9, A7..A2} as the column and set the bank from ba. A8 chooses the plain form (read 6, write 8, ap_o low) or the auto-precharge form (read 7, write 9, ap_o high).
- R5: Pins 0010 give code 10 (precharge one bank, with the bank from ba) when A8=0. They give code 11 (precharge all, bank 0) when A8=1.
- R6: Clock enable high then low, with NOP or deselect pins, gives code 13 and moves the power state to 1 (power-down).
- R7: Clock enable high then low, with the auto-refresh pins, gives code 15 and moves the power state to 2 (self-refresh). The same pins with clock enable high on both edges stay code 12, and the state stays 0.
- R8: Clock enable high then low with any other pins gives code 18 with illegal high. Any command flagged illegal leaves the power state unchanged.
- R9: Clock enable low then high gives code 14 from power-down or code 16 from self-refresh, and the state returns to 0. The same edge in the active state gives code 18 with illegal high.
- R10: For T_XPN edges after power-down wake-up, and for T_XSC edges after self-refresh wake-up, any command other than NOP or deselect keeps its code but raises illegal. Once the window is over, the same command is legal.
- R11: Termination disable is legal in the active state. It gives code 2 with illegal high while clock enable stays low in power-down or self-refresh.
- R12: The reserved pin pattern 0110 and a mode set with ba[1]=1 give code 18 with illegal high.
- R13: While clock enable is low on both edges, the code is 17 (hold) whatever the other pins carry (termination disable aside, see R11), and the power state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable sample |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address pins |
| cmd_o | output | 5 | Decoded command code |
| bank_o | output | 2 | Bank of the command, 0 otherwise |
| addr_o | output | 12 | Row (activate) or column (read/write), 0 otherwise |
| ap_o | output | 1 | Auto-precharge on read/write |
| pstate_o | output | 2 | Power state: 0 active, 1 power-down, 2 self-refresh |
| illegal_o | output | 1 | Command illegal or reserved |

## Verification
The bench goes after the edge-pair cases. A decoder that ignored the previous clock-enable sample would report auto refresh instead of self-refresh entry, and NOP instead of power-down entry. The bench also checks the last cycle of each wake-up window and the first cycle after it. An off-by-one counter would either flag a legal read or pass a forbidden one. Termination disable is driven both while awake and while asleep, and a wake-up edge is driven with no stored low-power state. A tracker that let illegal commands change state would leave the power state wrong after those cases.

// File: rtl/gcmd_pkg.sv
package gcmd_pkg;

  typedef enum logic [4:0] {
    CMD_DESEL = 5'd0,
    CMD_NOP   = 5'd1,
    CMD_TDIS  = 5'd2,
    CMD_MRS   = 5'd3,
    CMD_EMRS  = 5'd4,
    CMD_ACT   = 5'd5,
    CMD_RD    = 5'd6,
    CMD_RDA   = 5'd7,
    CMD_WR    = 5'd8,
    CMD_WRA   = 5'd9,
    CMD_PRE   = 5'd10,
    CMD_PREA  = 5'd11,
    CMD_AREF  = 5'd12,
    CMD_PDEN  = 5'd13,
    CMD_PDEX  = 5'd14,
    CMD_SREN  = 5'd15,
    CMD_SREX  = 5'd16,
    CMD_HOLD  = 5'd17,
    CMD_ILL   = 5'd18
  } cmd_e;

  typedef enum logic [1:0] {
    PS_ACT  = 2'd0,
    PS_PDN  = 2'd1,
    PS_SREF = 2'd2
  } pstate_e;

endpackage

// File: rtl/gcmd_pin_decode.sv
module gcmd_pin_decode
  import gcmd_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic mode_sel,
  input  logic mode_rsv,
  input  logic ap_bit,
  output cmd_e pin_cmd
);

  always_comb begin
    pin_cmd = CMD_ILL;
    if (cs_n) begin
      pin_cmd = (ras_n && cas_n && !we_n) ? CMD_TDIS : CMD_DESEL;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111: pin_cmd = CMD_NOP;
        3'b011: pin_cmd = CMD_ACT;
        3'b101: pin_cmd = ap_bit ? CMD_RDA : CMD_RD;
        3'b100: pin_cmd = ap_bit ? CMD_WRA : CMD_WR;
        3'b010: pin_cmd = ap_bit ? CMD_PREA : CMD_PRE;
        3'b001: pin_cmd = CMD_AREF;
        3'b000: pin_cmd = mode_rsv ? CMD_ILL : (mode_sel ? CMD_EMRS : CMD_MRS);
        default: pin_cmd = CMD_ILL;
      endcase
    end
  end

endmodule

// File: rtl/gcmd_exit_window.sv
module gcmd_exit_window #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             busy
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign busy = (cnt_q != '0);

  a_r10_window_reload: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt_q == $past(load_val)));

  a_r10_window_tick: assert property (@(posedge clk) disable iff (rst)
    (!load && busy) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/gcmd_power_ctl.sv
module gcmd_power_ctl
  import gcmd_pkg::*;
#(
  parameter int T_XPN = 3,
  parameter int T_XSC = 5,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke_prev,
  input  logic             cke,
  input  cmd_e             pin_cmd,
  input  logic             win_busy,
  output cmd_e             nxt_cmd,
  output logic             nxt_ill,
  output pstate_e          pstate,
  output logic             win_load,
  output logic [CNT_W-1:0] win_val
);

  pstate_e st_q, st_d;
  cmd_e    entry_cmd;
  logic    is_idle;

  assign is_idle = (pin_cmd == CMD_NOP) || (pin_cmd == CMD_DESEL);

  always_comb begin
    if (is_idle)                    entry_cmd = CMD_PDEN;
    else if (pin_cmd == CMD_AREF)   entry_cmd = CMD_SREN;
    else                            entry_cmd = CMD_ILL;
  end

  always_comb begin
    nxt_cmd  = pin_cmd;
    nxt_ill  = 1'b0;
    st_d     = st_q;
    win_load = 1'b0;
    win_val  = CNT_W'(T_XPN);
    unique case ({cke_prev, cke})
      2'b11: begin
        nxt_ill = (pin_cmd == CMD_ILL) || (win_busy && !is_idle);
      end
      2'b10: begin
        nxt_cmd = entry_cmd;
        if (entry_cmd == CMD_ILL || st_q != PS_ACT) begin
          nxt_cmd = CMD_ILL;
          nxt_ill = 1'b1;
        end else if (win_busy) begin
          nxt_ill = 1'b1;
        end else begin
          st_d = (entry_cmd == CMD_PDEN) ? PS_PDN : PS_SREF;
        end
      end
      2'b00: begin
        if (pin_cmd == CMD_TDIS && st_q != PS_ACT) nxt_ill = 1'b1;
        else                                        nxt_cmd = CMD_HOLD;
      end
      default: begin
        unique case (st_q)
          PS_PDN: begin
            nxt_cmd  = CMD_PDEX;
            win_load = 1'b1;
            st_d     = PS_ACT;
          end
          PS_SREF: begin
            nxt_cmd  = CMD_SREX;
            win_load = 1'b1;
            win_val  = CNT_W'(T_XSC);
            st_d     = PS_ACT;
          end
          default: begin
            nxt_cmd = CMD_ILL;
            nxt_ill = 1'b1;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= PS_ACT;
    else     st_q <= st_d;
  end

  assign pstate = st_q;

  a_r8_illegal_keeps_state: assert property (@(posedge clk) disable iff (rst)
    nxt_ill |=> (st_q == $past(st_q)));

  a_r9_wake_opens_window: assert property (@(posedge clk) disable iff (rst)
    (!cke_prev && cke && st_q != PS_ACT) |=> win_busy);

endmodule

// File: rtl/gcmd_field_extract.sv
module gcmd_field_extract
  import gcmd_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int BA_W    = 2,
  parameter int COL_LO  = 2,
  parameter int COL_HI  = 7,
  parameter int COL_TOP = 9
) (
  input  cmd_e              cmd,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   bank,
  output logic [ADDR_W-1:0] addr_f,
  output logic              ap
);

  localparam int COL_W = COL_HI - COL_LO + 2;

  logic [COL_W-1:0] col;
  logic             is_rw;

  assign col   = {addr[COL_TOP], addr[COL_HI:COL_LO]};
  assign is_rw = (cmd == CMD_RD) || (cmd == CMD_RDA) ||
                 (cmd == CMD_WR) || (cmd == CMD_WRA);

  always_comb begin
    bank   = '0;
    addr_f = '0;
    ap     = (cmd == CMD_RDA) || (cmd == CMD_WRA);
    if (cmd == CMD_ACT) begin
      bank   = ba;
      addr_f = addr;
    end else if (is_rw) begin
      bank   = ba;
      addr_f = ADDR_W'(col);
    end else if (cmd == CMD_PRE) begin
      bank   = ba;
    end
  end

endmodule

// File: rtl/gsdram_cmd_tracker.sv
module gsdram_cmd_tracker
  import gcmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int AP_BIT = 8,
  parameter int T_XPN  = 3,
  parameter int T_XSC  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic [4:0]        cmd_o,
  output logic [BA_W-1:0]   bank_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ap_o,
  output logic [1:0]        pstate_o,
  output logic              illegal_o
);

  localparam int T_MAX = (T_XPN > T_XSC) ? T_XPN : T_XSC;
  localparam int CNT_W = $clog2(T_MAX + 1);

  logic              cke_prev;
  cmd_e              pin_cmd, nxt_cmd;
  logic              nxt_ill, win_busy, win_load;
  logic [CNT_W-1:0]  win_val;
  pstate_e           pstate;
  logic [BA_W-1:0]   bank_d;
  logic [ADDR_W-1:0] addr_d;
  logic              ap_d;

  gcmd_pin_decode u_pins (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .mode_sel (ba[0]),
    .mode_rsv (ba[BA_W-1]),
    .ap_bit   (addr[AP_BIT]),
    .pin_cmd  (pin_cmd)
  );

  gcmd_power_ctl #(.T_XPN(T_XPN), .T_XSC(T_XSC), .CNT_W(CNT_W)) u_pwr (
    .clk      (clk),
    .rst      (rst),
    .cke_prev (cke_prev),
    .cke      (cke),
    .pin_cmd  (pin_cmd),
    .win_busy (win_busy),
    .nxt_cmd  (nxt_cmd),
    .nxt_ill  (nxt_ill),
    .pstate   (pstate),
    .win_load (win_load),
    .win_val  (win_val)
  );

  gcmd_exit_window #(.CNT_W(CNT_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .load     (win_load),
    .load_val (win_val),
    .busy     (win_busy)
  );

  gcmd_field_extract #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_fld (
    .cmd    (nxt_cmd),
    .ba     (ba),
    .addr   (addr),
    .bank   (bank_d),
    .addr_f (addr_d),
    .ap     (ap_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_prev  <= 1'b1;
      cmd_o     <= CMD_DESEL;
      bank_o    <= '0;
      addr_o    <= '0;
      ap_o      <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      cke_prev  <= cke;
      cmd_o     <= nxt_cmd;
      bank_o    <= bank_d;
      addr_o    <= addr_d;
      ap_o      <= ap_d;
      illegal_o <= nxt_ill;
    end
  end

  assign pstate_o = pstate;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (cmd_o == CMD_DESEL && pstate_o == 2'd0 && !illegal_o));

  a_r4_ap_only_rw: assert property (@(posedge clk) disable iff (rst)
    ap_o |-> (cmd_o == CMD_RDA || cmd_o == CMD_WRA));

  a_r6_pden_state: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_PDEN && !illegal_o) |-> (pstate_o == PS_PDN));

  a_r7_sren_state: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_SREN && !illegal_o) |-> (pstate_o == PS_SREF));

  a_r9_wake_active: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_PDEX || cmd_o == CMD_SREX) |-> (pstate_o == PS_ACT && !illegal_o));

  a_r12_ill_flagged: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_ILL) |-> illegal_o);

  a_r13_hold_stable: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_HOLD) |-> $stable(pstate_o));

endmodule

// File: tb/sim_gsdram_cmd_tracker.sv
module sim_gsdram_cmd_tracker;

  localparam logic [3:0] P_NOP = 4'b0111, P_DES = 4'b1111, P_TD  = 4'b1110,
                         P_ACT = 4'b0011, P_RD  = 4'b0101, P_WR  = 4'b0100,
                         P_PRE = 4'b0010, P_REF = 4'b0001, P_MRS = 4'b0000,
                         P_RSV = 4'b0110;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [11:0] addr = '0;
  logic [4:0]  cmd_o;
  logic [1:0]  bank_o;
  logic [11:0] addr_o;
  logic        ap_o;
  logic [1:0]  pstate_o;
  logic        illegal_o;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gsdram_cmd_tracker u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o),
    .bank_o(bank_o), .addr_o(addr_o), .ap_o(ap_o), .pstate_o(pstate_o),
    .illegal_o(illegal_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic k, input logic [3:0] p, input logic [1:0] b,
                      input logic [11:0] a);
    cke = k;
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b;
    addr = a;
    @(negedge clk);
  endtask

  task automatic expect3(input string tag, input int c, input int ill, input int st);
    chk({tag, " cmd"}, int'(cmd_o), c);
    chk({tag, " illegal"}, int'(illegal_o), ill);
    chk({tag, " state"}, int'(pstate_o), st);
  endtask

  task automatic t_reset;
    chk("R1 cmd", int'(cmd_o), 0);
    chk("R1 state", int'(pstate_o), 0);
    chk("R1 illegal", int'(illegal_o), 0);
    chk("R1 bank", int'(bank_o), 0);
    chk("R1 addr", int'(addr_o), 0);
    chk("R1 ap", int'(ap_o), 0);
  endtask

  task automatic t_plain;
    step(1, P_NOP, 0, 0);          expect3("R2 nop", 1, 0, 0);
    step(1, P_DES, 0, 0);          expect3("R2 desel", 0, 0, 0);
    step(1, 4'b1010, 0, 0);        expect3("R2 desel other", 0, 0, 0);
    step(1, P_TD, 0, 0);           expect3("R2 R11 tdis active", 2, 0, 0);
    step(1, P_MRS, 2'b00, 12'h123); expect3("R2 mrs", 3, 0, 0);
    step(1, P_MRS, 2'b01, 12'h123); expect3("R2 emrs", 4, 0, 0);
    step(1, P_REF, 0, 0);          expect3("R2 R7 aref", 12, 0, 0);
  endtask

  task automatic t_addr;
    step(1, P_ACT, 2'd2, 12'hABC);
    expect3("R3 act", 5, 0, 0);
    chk("R3 bank", int'(bank_o), 2);
    chk("R3 row", int'(addr_o), 12'hABC);
    step(1, P_RD, 2'd3, 12'h2B4);
    expect3("R4 rd", 6, 0, 0);
    chk("R4 rd col", int'(addr_o), 7'h6D);
    chk("R4 rd bank", int'(bank_o), 3);
    chk("R4 rd ap", int'(ap_o), 0);
    step(1, P_RD, 2'd1, 12'h3B4);
    expect3("R4 rda", 7, 0, 0);
    chk("R4 rda col", int'(addr_o), 7'h6D);
    chk("R4 rda ap", int'(ap_o), 1);
    step(1, P_WR, 2'd1, 12'h004);
    expect3("R4 wr", 8, 0, 0);
    chk("R4 wr col", int'(addr_o), 1);
    chk("R4 wr ap", int'(ap_o), 0);
    step(1, P_WR, 2'd0, 12'h300);
    expect3("R4 wra", 9, 0, 0);
    chk("R4 wra col", int'(addr_o), 7'h40);
    chk("R4 wra ap", int'(ap_o), 1);
    step(1, P_PRE, 2'd3, 12'h000);
    expect3("R5 pre", 10, 0, 0);
    chk("R5 pre bank", int'(bank_o), 3);
    step(1, P_PRE, 2'd3, 12'h100);
    expect3("R5 prea", 11, 0, 0);
    chk("R5 prea bank", int'(bank_o), 0);
  endtask

  task automatic t_powerdown;
    step(0, P_NOP, 0, 0);          expect3("R6 pden", 13, 0, 1);
    step(0, P_ACT, 1, 12'h0FF);    expect3("R13 hold", 17, 0, 1);
    step(0, P_TD, 0, 0);           expect3("R11 tdis in pd", 2, 1, 1);
    step(1, P_ACT, 0, 0);          expect3("R9 pdex", 14, 0, 0);
    step(1, P_NOP, 0, 0);          expect3("R10 xpn w1 nop", 1, 0, 0);
    step(1, P_ACT, 0, 0);          expect3("R10 xpn w2 act", 5, 1, 0);
    step(1, P_DES, 0, 0);          expect3("R10 xpn w3 desel", 0, 0, 0);
    step(1, P_ACT, 0, 0);          expect3("R10 xpn after act", 5, 0, 0);
  endtask

  task automatic t_selfref;
    step(0, P_REF, 0, 0);          expect3("R7 sren", 15, 0, 2);
    step(0, P_TD, 0, 0);           expect3("R11 tdis in sr", 2, 1, 2);
    step(0, P_RD, 0, 0);           expect3("R13 hold sr", 17, 0, 2);
    step(1, P_NOP, 0, 0);          expect3("R9 srex", 16, 0, 0);
    for (int i = 0; i < 4; i++) begin
      step(1, P_NOP, 0, 0);        expect3("R10 xsc nop", 1, 0, 0);
    end
    step(1, P_RD, 0, 0);           expect3("R10 xsc last rd", 6, 1, 0);
    step(1, P_RD, 0, 0);           expect3("R10 xsc after rd", 6, 0, 0);
  endtask

  task automatic t_illegal;
    step(0, P_RD, 0, 0);           expect3("R8 bad entry", 18, 1, 0);
    step(0, P_NOP, 0, 0);          expect3("R13 low while active", 17, 0, 0);
    step(1, P_NOP, 0, 0);          expect3("R9 wake from active", 18, 1, 0);
    step(1, P_RSV, 0, 0);          expect3("R12 reserved", 18, 1, 0);
    step(1, P_MRS, 2'b10, 0);      expect3("R12 mode ba1", 18, 1, 0);
    step(1, P_NOP, 0, 0);          expect3("R8 back to nop", 1, 0, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired (R1..R13 run incomplete)");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    step(1, P_NOP, 0, 0);
    t_plain;
    t_addr;
    t_powerdown;
    t_selfref;
    t_illegal;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule